// File: doc/BRIEF.md
# Approximate Counter-Tree 8x8 Multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product. Every partial-product bit is a single AND gate. The bits are then sorted into columns by weight. Two stages of 6:3 counters each take six bits of a column and return a three-bit count. The count's weight-1 bit stays in the same column, its weight-2 bit goes one column up and its weight-4 bit goes two columns up. One row of full adders then brings every column down to two rows. A 16-bit carry-propagate adder produces the product, and a register holds it.

A single mode input chooses how the counters work. In exact mode the product is the true product. In approximate mode the counters in a band of middle columns are replaced by a cheaper counter that can miscount. This trades a bounded error for simpler logic, which suits image and media data. Columns outside the band, and all the full adders, stay exact.

Top module: `amul_ctr8`

## Requirements
- R1: When `rst` is high at a rising clock edge, `product` becomes 0 at that edge, whatever the inputs.
- R2: With `mode` = 0 (exact), `product` equals `a*b` for every operand pair. The result appears one clock edge after the operands and mode are sampled.
- R3: The 6:3 counter takes inputs x0..x5, paired as (x0,x1), (x2,x3) and (x4,x5). When exact, its outputs {w4,w2,w1} are the number of ones in its inputs. When approximate, the outputs are:
  - w4: 1 when at least four inputs are 1 (this bit stays exact);
  - w2: 1 when the two bits of any pair are both 1;
  - w1: the XOR of the three pair-ORs.
- R4: The partial product a[j]&b[i] sits in column i+j. Its slot in that column is i minus (c-7 when c>7, else 0), where c is the column. Each counter stage works on every column as follows:
  - it counts slots 0..5;
  - slot 0 of the new column c takes w1 from counter c;
  - slot 1 takes w2 from counter c-1;
  - slot 2 takes w4 from counter c-2;
  - slots 3 and 4 carry over old slots 6 and 7;
  - bits that would land beyond column 15 are dropped.

  After two such stages, one full adder per column compresses slots 0..2. A 16-bit adder then adds the resulting two rows, modulo 2^16.
- R5: With `mode` = 1 (approximate), both counter stages use the approximate counter in columns 5 through 9 only. Every other counter and every full adder stays exact. The product equals the bit-exact result of the R4 tree under this rule.
- R6: In both modes, product bits 4..0 equal bits 4..0 of `a*b`.
- R7: In approximate mode, when either operand has at most one bit set, the product equals `a*b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the product register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the product register |
| a | input | 8 | Unsigned multiplicand |
| b | input | 8 | Unsigned multiplier |
| mode | input | 1 | 0 = exact product, 1 = approximate middle band |
| product | output | 16 | Registered product |

## Verification
On every cycle, the assertions check the reset value and the exact product in exact mode. They also check that the low five bits match the exact product in both modes, and that approximate mode is still exact when an operand has at most one bit set. Inside the counters, the assertions check the exact count and the exact weight-4 bit. They also check that exact mode never drops a bit beyond column 15.

Only the bench's scenarios can show the bit-exact approximate result of R5. That result depends on slot order and on the band limits, and no single-cycle property captures it. The bench therefore sweeps all 65536 operand pairs in each mode. It checks approximate mode against its own model of the tree and reports the mean and worst error distance, normalised to 65025.

// File: rtl/amul_pkg.sv
package amul_pkg;
  typedef enum logic {MODE_EXACT = 1'b0, MODE_APPROX = 1'b1} mode_e;

  // number of 6:3 stages that bring a column of height n down to three bits
  function automatic int red_stages(input int n);
    return (n - 1) / 3;
  endfunction
endpackage

// File: rtl/ctr63.sv
module ctr63 (
  input  logic [5:0] x,
  input  logic       approx,
  output logic [2:0] y
);
  logic [2:0] p_and, p_or;
  logic [1:0] pc0, pc1, pc2;
  logic [2:0] ex;

  always_comb begin
    for (int k = 0; k < 3; k++) begin
      p_and[k] = x[2*k] & x[2*k+1];
      p_or[k]  = x[2*k] | x[2*k+1];
    end
    pc0 = {p_and[0], p_or[0] & ~p_and[0]};
    pc1 = {p_and[1], p_or[1] & ~p_and[1]};
    pc2 = {p_and[2], p_or[2] & ~p_and[2]};
    ex  = {1'b0, pc0} + {1'b0, pc1} + {1'b0, pc2};
    if (approx) y = {ex[2], |p_and, ^p_or};
    else        y = ex;
  end

  // R3: the exact counter returns the number of ones; w4 is exact in both variants
  always_comb begin
    a_r3_exact_count: assert (approx || (y == 3'($countones(x))));
    a_r3_w4_exact: assert (y[2] == ($countones(x) >= 4));
  end
endmodule

// File: rtl/ctr_stage.sv
module ctr_stage #(
  parameter int N       = 8,
  parameter int PW      = 16,
  parameter int BAND_LO = 5,
  parameter int BAND_HI = 9
) (
  input  logic [PW-1:0][N-1:0] cin,
  input  logic                 approx,
  output logic [PW-1:0][N-1:0] cout
);
  logic [PW-1:0][2:0] r;
  logic [2:0] spill;

  for (genvar c = 0; c < PW; c++) begin : g_col
    localparam bit IN_BAND = (c >= BAND_LO) && (c <= BAND_HI);
    ctr63 u_ctr (.x(cin[c][5:0]), .approx(approx & IN_BAND), .y(r[c]));

    assign cout[c][0] = r[c][0];
    if (c >= 1) begin : g_w2
      assign cout[c][1] = r[c-1][1];
    end else begin : g_w2_none
      assign cout[c][1] = 1'b0;
    end
    if (c >= 2) begin : g_w4
      assign cout[c][2] = r[c-2][2];
    end else begin : g_w4_none
      assign cout[c][2] = 1'b0;
    end
    for (genvar k = 0; k < N - 6; k++) begin : g_keep
      assign cout[c][3+k] = cin[c][6+k];
    end
    for (genvar k = N - 3; k < N; k++) begin : g_zero
      assign cout[c][k] = 1'b0;
    end
  end

  assign spill = {r[PW-1][2], r[PW-1][1], r[PW-2][2]};

  // R2: an exact product never reaches past the top column
  always_comb begin
    a_r2_stage_spill: assert (approx || (spill == 3'b000));
  end
endmodule

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ z;
  assign co = (x & y) | (z & (x ^ y));
endmodule

// File: rtl/amul_ctr8.sv
module amul_ctr8
  import amul_pkg::*;
#(
  parameter int N       = 8,
  parameter int BAND_LO = 5,
  parameter int BAND_HI = 9,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    a,
  input  logic [N-1:0]    b,
  input  logic            mode,
  output logic [2*N-1:0]  product
);
  localparam int PW   = 2 * N;
  localparam int NSTG = red_stages(N);

  logic approx;
  logic [NSTG:0][PW-1:0][N-1:0] st;
  logic [PW-1:0] row0, row1, fa_c, tall, sum_w;

  assign approx = (mode == MODE_APPROX);

  // partial products, ordered by multiplier row inside each column
  for (genvar c = 0; c < PW; c++) begin : g_pp_col
    for (genvar k = 0; k < N; k++) begin : g_pp_slot
      localparam int ROW = k + ((c > N - 1) ? (c - N + 1) : 0);
      if ((ROW <= N - 1) && (ROW <= c)) begin : g_bit
        assign st[0][c][k] = a[c-ROW] & b[ROW];
      end else begin : g_pad
        assign st[0][c][k] = 1'b0;
      end
    end
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    ctr_stage #(.N(N), .PW(PW), .BAND_LO(BAND_LO), .BAND_HI(BAND_HI)) u_stage (
      .cin(st[s]), .approx(approx), .cout(st[s+1])
    );
  end

  // final 3:2 row, then the carry-propagate adder
  assign row1[0] = 1'b0;
  for (genvar c = 0; c < PW; c++) begin : g_fa
    fa_cell u_fa (
      .x(st[NSTG][c][0]), .y(st[NSTG][c][1]), .z(st[NSTG][c][2]),
      .s(row0[c]), .co(fa_c[c])
    );
    if (c < PW - 1) begin : g_carry
      assign row1[c+1] = fa_c[c];
    end
    assign tall[c] = |st[NSTG][c][N-1:3];
  end

  assign sum_w = row0 + row1;

  // R4: after the counter stages every column is at most three bits tall
  // R2: the full-adder row drops nothing in exact mode
  always_comb begin
    a_r4_height: assert (tall == '0);
    a_r2_no_spill: assert (approx || !fa_c[PW-1]);
  end

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= sum_w;
    end
    assign product = q;

    a_r1_reset: assert property (@(posedge clk) rst |=> (product == '0));
    a_r2_exact: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_EXACT) |=> (product == (PW'($past(a)) * PW'($past(b)))));
    a_r6_low_bits: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (product[BAND_LO-1:0] == BAND_LO'(PW'($past(a)) * PW'($past(b)))));
    a_r7_sparse: assert property (@(posedge clk) disable iff (rst)
      ((mode == MODE_APPROX) && (($countones(a) <= 1) || ($countones(b) <= 1)))
      |=> (product == (PW'($past(a)) * PW'($past(b)))));
  end else begin : g_comb
    assign product = sum_w;
  end
endmodule

// File: tb/test_amul_ctr8.sv
module test_amul_ctr8;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  a = 8'd0;
  logic [7:0]  b = 8'd0;
  logic        mode = 1'b0;
  logic [15:0] product;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  real  ned_sum = 0.0;
  real  ned_max = 0.0;

  amul_ctr8 i_amul_ctr8 (.clk(clk), .rst(rst), .a(a), .b(b), .mode(mode), .product(product));

  always #10 clk = ~clk;

  // counter as required by R3
  function automatic logic [2:0] ctr_ref(input logic [5:0] x, input logic apx);
    int n;
    n = $countones(x);
    if (!apx) return 3'(n);
    return {n >= 4, (x[0] & x[1]) | (x[2] & x[3]) | (x[4] & x[5]),
            (x[0] | x[1]) ^ (x[2] | x[3]) ^ (x[4] | x[5])};
  endfunction

  // tree value as required by R4 and R5
  function automatic logic [15:0] tree_ref(input logic [7:0] x, input logic [7:0] y, input logic apx);
    logic [7:0] col [16];
    logic [7:0] nxt [16];
    logic [2:0] r;
    int base;
    int v;
    for (int c = 0; c < 16; c++) begin
      col[c] = 8'd0;
      base = (c > 7) ? c - 7 : 0;
      for (int i = base; i <= 7 && i <= c; i++) col[c][i-base] = x[c-i] & y[i];
    end
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 16; c++) nxt[c] = 8'd0;
      for (int c = 0; c < 16; c++) begin
        r = ctr_ref(col[c][5:0], apx && c >= 5 && c <= 9);
        nxt[c][0] = r[0];
        if (c + 1 < 16) nxt[c+1][1] = r[1];
        if (c + 2 < 16) nxt[c+2][2] = r[2];
        nxt[c][3] = col[c][6];
        nxt[c][4] = col[c][7];
      end
      for (int c = 0; c < 16; c++) col[c] = nxt[c];
    end
    v = 0;
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 8; k++) v += int'(col[c][k]) << c;
    return v[15:0];
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      if (n_errors <= 20)
        $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  task automatic check_pair(input logic [7:0] pa, input logic [7:0] pb, input logic pm);
    logic [15:0] exact;
    real d;
    exact = 16'(pa) * 16'(pb);
    if (!pm) begin
      check("R2 exact product", product, exact);
    end else begin
      check("R3,R4,R5 approximate tree", product, tree_ref(pa, pb, 1'b1));
      check("R6 low bits", {11'd0, product[4:0]}, {11'd0, exact[4:0]});
      if ($countones(pa) <= 1 || $countones(pb) <= 1)
        check("R7 sparse operand", product, exact);
      d = (product > exact) ? real'(product - exact) : real'(exact - product);
      d = d / 65025.0;
      ned_sum += d;
      if (d > ned_max) ned_max = d;
    end
  endtask

  initial begin
    logic [7:0] pa, pb;
    logic pm;
    bit have;
    a = 8'hA5; b = 8'h3C; mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", product, 16'h0000);
    // R4 sanity: the exact tree model matches true multiplication
    check("R4 model", tree_ref(8'hFF, 8'hFF, 1'b0), 16'hFE01);
    rst = 1'b0;
    have = 1'b0;
    pa = 8'd0; pb = 8'd0; pm = 1'b0;
    for (int m = 0; m < 2; m++) begin
      for (int idx = 0; idx < 65536; idx++) begin
        if (have) check_pair(pa, pb, pm);
        a = idx[15:8]; b = idx[7:0]; mode = m[0];
        pa = a; pb = b; pm = mode; have = 1'b1;
        @(negedge clk);
      end
    end
    check_pair(pa, pb, pm);
    // R1 again mid-run with live operands
    a = 8'hFF; b = 8'hFF; mode = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", product, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R3,R5 all-ones approximate", product, tree_ref(8'hFF, 8'hFF, 1'b1));
    $display("approximate mode: mean NED %f, max NED %f", ned_sum / 65536.0, ned_max);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end
endmodule